// File: doc/BRIEF.md
# Shared-Line Interrupt Trigger Conditioner

This block sits in front of the request register of an eight-input interrupt controller. Several sources may drive the same input, so the block does not sample a wire. It keeps a count per input of how many sources currently hold that input asserted. A source reports a change by sending a command. The command is an assert, a deassert, or a pulse, which is an assert followed at once by a deassert. Each command carries the index of the input it acts on. The count moves up or down. Request edges are derived from the count changes, and each input's trigger mode is taken into account.

For each input, a configuration register selects edge or level trigger. Some inputs are wired as edge only, so their level bits can never be set. The primary instance keeps inputs 0, 1 and 2 edge only. The secondary instance keeps inputs 0 and 5 edge only. The block sends one-cycle set and clear strobes to the priority core, and it shows which inputs are currently held by at least one source. Saturation at either end of a count raises a one-cycle error flag and advances a statistics counter. While the controller reports that it is not ready, source commands are dropped.

Top module: `shared_line_trigger`

## Requirements
- R1: After reset all counts, the configuration register, the strobes, the error flags and both statistics counters are zero.
- R2: Each command has an op code: 2'b00 asserts, 2'b01 deasserts, 2'b10 pulses and 2'b11 does nothing. An assert adds one to the selected input's count and a deassert subtracts one. Bit i of `pinActive` is high exactly when the count of input i is non-zero.
- R3: An assert on a count of 2^CNT_W-1 leaves the count unchanged, pulses `satHigh` and adds one to `satHighCount`. A deassert on a count of 0 leaves it at 0, pulses `satLow` and adds one to `satLowCount`.
- R4: `reqSet[i]` pulses when a count of input i goes from 0 to 1. It also pulses when input i is in level mode and any assert or deassert leaves its count above 0.
- R5: `reqClr[i]` pulses when a count of input i goes from 1 to 0, but only if input i is in level mode. A count reaching 0 on an edge-mode input produces no clear.
- R6: A pulse command applies the assert step and then the deassert step within the same command, and both strobes may result. If the assert step saturates, the deassert step is skipped.
- R7: Bit i of the configuration register selects level mode for input i when it is 1. A write stores the data ANDed with 8'hF8 on the primary instance and with 8'hDE on the secondary instance. `cfgRdData` always shows the stored value.
- R8: While `ready` is low, commands change no count, no strobe, no flag and no counter.
- R9: The strobes and flags for a command appear in the cycle after the clock edge that takes the command, and they last exactly one cycle. When no command is taken they are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ready | input | 1 | Controller initialised; commands are accepted only while high |
| cmdValid | input | 1 | Command strobe |
| cmdPin | input | 3 | Input index for the command |
| cmdOp | input | 2 | Op code: 00 assert, 01 deassert, 10 pulse, 11 none |
| cfgWrEn | input | 1 | Write strobe for the trigger-mode register |
| cfgWrData | input | 8 | Write data for the trigger-mode register |
| cfgRdData | output | 8 | Stored trigger-mode register (1 = level) |
| reqSet | output | 8 | One-cycle request-set strobes |
| reqClr | output | 8 | One-cycle request-clear strobes |
| pinActive | output | 8 | Inputs whose count is non-zero |
| satHigh | output | 1 | One-cycle flag: an assert saturated |
| satLow | output | 1 | One-cycle flag: a deassert saturated |
| satHighCount | output | STAT_W | Number of high saturations |
| satLowCount | output | STAT_W | Number of low saturations |

## Verification
The counts, the configuration register, the strobes, the flags and the statistics counters are all updated on the clock edge that takes the command or write. All of these results are therefore due one edge later, and `pinActive` is due at that same edge because it is decoded directly from the counts. The bench drives each stimulus at a falling edge and lets exactly one rising edge pass. It then compares every output with its reference model at the next falling edge. Idle cycles are checked the same way, which shows that the strobes last only one cycle.

// File: rtl/trig_cond_pkg.sv
package trig_cond_pkg;
  localparam int PIN_COUNT = 8;
  localparam int PIN_W = $clog2(PIN_COUNT);

  typedef enum logic [1:0] {
    OP_ASSERT   = 2'b00,
    OP_DEASSERT = 2'b01,
    OP_PULSE    = 2'b10,
    OP_NONE     = 2'b11
  } trigOp_e;

  // Strobes from control to datapath for the selected input
  typedef struct packed {
    logic incEn;
    logic decEn;
  } trigStrobe_t;

  // Bits that may hold level mode; the rest stay edge only
  function automatic logic [PIN_COUNT-1:0] levelAllowMask(input bit isPrimary);
    return isPrimary ? 8'hF8 : 8'hDE;
  endfunction
endpackage

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_cond_pkg::*;
#(
  parameter int STAT_W = 16,
  parameter bit IS_PRIMARY = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ready,
  input  logic                 cmdValid,
  input  logic [PIN_W-1:0]     cmdPin,
  input  logic [1:0]           cmdOp,
  input  logic                 cfgWrEn,
  input  logic [PIN_COUNT-1:0] cfgWrData,
  input  logic                 satHiEv,
  input  logic                 satLoEv,
  output trigStrobe_t          strobe,
  output logic [PIN_COUNT-1:0] pinSel,
  output logic [PIN_COUNT-1:0] levelMode,
  output logic                 satHigh,
  output logic                 satLow,
  output logic [STAT_W-1:0]    satHighCount,
  output logic [STAT_W-1:0]    satLowCount
);
  localparam logic [PIN_COUNT-1:0] ALLOW = levelAllowMask(IS_PRIMARY);

  trigOp_e opCode;
  logic    take;

  always_comb begin
    opCode = trigOp_e'(cmdOp);
    take   = cmdValid && ready;
    strobe.incEn = take && (opCode == OP_ASSERT || opCode == OP_PULSE);
    strobe.decEn = take && (opCode == OP_DEASSERT || opCode == OP_PULSE);
    pinSel = '0;
    pinSel[cmdPin] = take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      levelMode    <= '0;
      satHigh      <= 1'b0;
      satLow       <= 1'b0;
      satHighCount <= '0;
      satLowCount  <= '0;
    end else begin
      if (cfgWrEn) levelMode <= cfgWrData & ALLOW;
      satHigh <= satHiEv;
      satLow  <= satLoEv;
      if (satHiEv) satHighCount <= satHighCount + 1'b1;
      if (satLoEv) satLowCount  <= satLowCount + 1'b1;
    end
  end
endmodule

// File: rtl/trig_dp.sv
module trig_dp
  import trig_cond_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  trigStrobe_t          strobe,
  input  logic [PIN_COUNT-1:0] pinSel,
  input  logic [PIN_COUNT-1:0] levelMode,
  output logic [PIN_COUNT-1:0] reqSet,
  output logic [PIN_COUNT-1:0] reqClr,
  output logic [PIN_COUNT-1:0] pinActive,
  output logic                 satHiEv,
  output logic                 satLoEv
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [PIN_COUNT-1:0] hiSatVec, loSatVec, setNext, clrNext;

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    logic [CNT_W-1:0] cnt, midCnt, newCnt;
    logic incHit, decHit, atMax, hiSat, loSat, setA, setD, clrD;

    always_comb begin
      incHit = pinSel[i] && strobe.incEn;
      atMax  = &cnt;
      hiSat  = incHit && atMax;
      midCnt = (incHit && !atMax) ? cnt + ONE : cnt;
      // deassert step of a pulse is dropped when its assert step saturated
      decHit = pinSel[i] && strobe.decEn && !hiSat;
      loSat  = decHit && (midCnt == '0);
      newCnt = (decHit && !loSat) ? midCnt - ONE : midCnt;
      setA   = incHit && ((cnt == '0 && midCnt == ONE) || (levelMode[i] && midCnt != '0));
      setD   = decHit && !loSat && levelMode[i] && newCnt != '0;
      clrD   = decHit && levelMode[i] && midCnt == ONE;
      hiSatVec[i] = hiSat;
      loSatVec[i] = loSat;
      setNext[i]  = setA || setD;
      clrNext[i]  = clrD;
      pinActive[i] = cnt != '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= newCnt;
    end
  end

  assign satHiEv = |hiSatVec;
  assign satLoEv = |loSatVec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqSet <= '0;
      reqClr <= '0;
    end else begin
      reqSet <= setNext;
      reqClr <= clrNext;
    end
  end
endmodule

// File: rtl/shared_line_trigger.sv
module shared_line_trigger
  import trig_cond_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int STAT_W = 16,
  parameter bit IS_PRIMARY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready,
  input  logic              cmdValid,
  input  logic [2:0]        cmdPin,
  input  logic [1:0]        cmdOp,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  output logic [7:0]        reqSet,
  output logic [7:0]        reqClr,
  output logic [7:0]        pinActive,
  output logic              satHigh,
  output logic              satLow,
  output logic [STAT_W-1:0] satHighCount,
  output logic [STAT_W-1:0] satLowCount
);
  trigStrobe_t          strobe;
  logic [PIN_COUNT-1:0] pinSel, levelMode;
  logic                 satHiEv, satLoEv;

  trig_ctrl #(.STAT_W(STAT_W), .IS_PRIMARY(IS_PRIMARY)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ready(ready), .cmdValid(cmdValid),
    .cmdPin(cmdPin), .cmdOp(cmdOp), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .satHiEv(satHiEv), .satLoEv(satLoEv), .strobe(strobe), .pinSel(pinSel),
    .levelMode(levelMode), .satHigh(satHigh), .satLow(satLow),
    .satHighCount(satHighCount), .satLowCount(satLowCount)
  );

  trig_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .pinSel(pinSel),
    .levelMode(levelMode), .reqSet(reqSet), .reqClr(reqClr),
    .pinActive(pinActive), .satHiEv(satHiEv), .satLoEv(satLoEv)
  );

  assign cfgRdData = levelMode;
endmodule

// File: rtl/trig_cond_chk.sv
module trig_cond_chk
  import trig_cond_pkg::*;
#(
  parameter bit IS_PRIMARY = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ready,
  input logic       cmdValid,
  input logic [1:0] cmdOp,
  input logic [7:0] cfgRdData,
  input logic [7:0] reqSet,
  input logic [7:0] reqClr,
  input logic [7:0] pinActive,
  input logic       satHigh,
  input logic       satLow
);
  localparam logic [7:0] ALLOW = levelAllowMask(IS_PRIMARY);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmdValid && ready && cmdOp != 2'b11) |=> (reqSet == '0 && reqClr == '0 && !satHigh && !satLow));

  // R8
  not_ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(pinActive));

  // R7
  edge_only_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgRdData & ~ALLOW) == '0);

  // R5
  clr_level_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqClr != '0 |-> (reqClr & ~$past(cfgRdData)) == '0);

  // R4
  set_single_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reqSet) && $onehot0(reqClr));

  // R6
  sat_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(satHigh && satLow));
endmodule

bind shared_line_trigger trig_cond_chk #(.IS_PRIMARY(IS_PRIMARY)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .cfgRdData(cfgRdData), .reqSet(reqSet), .reqClr(reqClr),
  .pinActive(pinActive), .satHigh(satHigh), .satLow(satLow)
);

// File: tb/shared_line_trigger_bench.sv
`timescale 1ns/1ps
module shared_line_trigger_bench;
  localparam int MAXC = 255;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ready = 1'b0, cmdValid = 1'b0, cfgWrEn = 1'b0;
  logic [2:0] cmdPin = '0;
  logic [1:0] cmdOp = 2'b11;
  logic [7:0] cfgWrData = '0;
  logic [7:0] cfgRdData, reqSet, reqClr, pinActive;
  logic satHigh, satLow;
  logic [15:0] satHighCount, satLowCount;
  logic [7:0] sCfg, sSet, sClr, sAct;
  logic sHi, sLo;
  logic [15:0] sHiC, sLoC;

  int checks = 0, errors = 0;
  int mCnt [8];
  logic [7:0] mLvl = '0, mLvlS = '0, eSet, eClr;
  logic eHi, eLo;
  int mHiC = 0, mLoC = 0;

  always #2.5 clk = ~clk;

  shared_line_trigger #(.IS_PRIMARY(1'b1)) u_shared_line_trigger (
    .clk(clk), .rst_n(rst_n), .ready(ready), .cmdValid(cmdValid), .cmdPin(cmdPin),
    .cmdOp(cmdOp), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .reqSet(reqSet), .reqClr(reqClr), .pinActive(pinActive), .satHigh(satHigh),
    .satLow(satLow), .satHighCount(satHighCount), .satLowCount(satLowCount));

  shared_line_trigger #(.IS_PRIMARY(1'b0)) u_shared_line_trigger_sec (
    .clk(clk), .rst_n(rst_n), .ready(ready), .cmdValid(cmdValid), .cmdPin(cmdPin),
    .cmdOp(cmdOp), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(sCfg),
    .reqSet(sSet), .reqClr(sClr), .pinActive(sAct), .satHigh(sHi),
    .satLow(sLo), .satHighCount(sHiC), .satLowCount(sLoC));

  task automatic chk(input string req, input string ph, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] actual %0h expected %0h", req, ph, act, exp);
    end
  endtask

  function automatic logic [7:0] activeVec();
    logic [7:0] v = '0;
    for (int i = 0; i < 8; i++) v[i] = mCnt[i] != 0;
    return v;
  endfunction

  // Reference model of one accepted stimulus
  task automatic model(input logic v, input int p, input logic [1:0] op,
                       input logic rdy, input logic we, input logic [7:0] d);
    eSet = '0; eClr = '0; eHi = 0; eLo = 0;
    if (v && rdy && op != 2'b11) begin
      int c = mCnt[p];
      logic lv = mLvl[p];
      if (op == 2'b00 || op == 2'b10) begin
        int o = c;
        if (c == MAXC) eHi = 1; else c++;
        if ((o == 0 && c == 1) || (lv && c > 0)) eSet[p] = 1;
      end
      if ((op == 2'b01 || op == 2'b10) && !eHi) begin
        if (c == 0) eLo = 1;
        else begin
          c--;
          if (lv && c > 0) eSet[p] = 1;
          if (lv && c == 0) eClr[p] = 1;
        end
      end
      mCnt[p] = c;
      if (eHi) mHiC++;
      if (eLo) mLoC++;
    end
    if (we) begin
      mLvl  = d & 8'hF8;
      mLvlS = d & 8'hDE;
    end
  endtask

  task automatic step(input string ph, input logic v, input int p, input logic [1:0] op,
                      input logic rdy = 1'b1, input logic we = 1'b0, input logic [7:0] d = '0);
    cmdValid = v; cmdPin = 3'(p); cmdOp = op; ready = rdy; cfgWrEn = we; cfgWrData = d;
    model(v, p, op, rdy, we, d);
    @(posedge clk);
    @(negedge clk);
    chk("R2", ph, pinActive, activeVec());
    chk("R4", ph, reqSet, eSet);
    chk("R5", ph, reqClr, eClr);
    chk("R3", ph, {satHigh, satLow}, {eHi, eLo});
    chk("R3", ph, {satHighCount, satLowCount}, {16'(mHiC), 16'(mLoC)});
    chk("R7", ph, {cfgRdData, sCfg}, {mLvl, mLvlS});
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 8; i++) mCnt[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset", {reqSet, reqClr, pinActive, cfgRdData}, 0);
    chk("R1", "reset", {satHigh, satLow, satHighCount, satLowCount}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: masked configuration writes on both instances
    step("R7 mask", 0, 0, 2'b11, 1, 1, 8'hFF);
    step("R7 mask2", 0, 0, 2'b11, 1, 1, 8'h3C);
    step("R7 cfg", 0, 0, 2'b11, 1, 1, 8'h30);
    // R4/R5 edge input 1: latched set, no clear
    step("R4 edge", 1, 1, 2'b00);
    step("R4 edge2", 1, 1, 2'b00);
    step("R5 edge", 1, 1, 2'b01);
    step("R5 edge2", 1, 1, 2'b01);
    step("R9 idle", 0, 1, 2'b00);
    // R4/R5 level input 4
    step("R4 lvl", 1, 4, 2'b00);
    step("R4 lvl2", 1, 4, 2'b00);
    step("R4 lvl3", 1, 4, 2'b01);
    step("R5 lvl", 1, 4, 2'b01);
    // R6: pulses on edge input 0 and level input 5
    step("R6 edge", 1, 0, 2'b10);
    step("R6 lvl", 1, 5, 2'b10);
    step("R6 lvl2", 1, 5, 2'b00);
    step("R6 lvl3", 1, 5, 2'b10);
    step("R2 nop", 1, 5, 2'b11);
    // R8: not ready ignores commands
    step("R8", 1, 3, 2'b00, 0);
    step("R8b", 1, 5, 2'b01, 0);
    step("R8c", 0, 3, 2'b11);
    // R3: low saturation
    step("R3 low", 1, 6, 2'b01);
    // R3/R6: high saturation on input 7
    for (int i = 0; i < MAXC; i++) step("R3 fill", 1, 7, 2'b00);
    step("R3 high", 1, 7, 2'b00);
    step("R6 sat", 1, 7, 2'b10);
    step("R3 down", 1, 7, 2'b01);
    step("R6 pulse", 1, 7, 2'b10);
    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic rdy = ($urandom % 10) != 0;
      logic we  = ($urandom % 20) == 0;
      step("random", ($urandom % 4) != 0, int'($urandom % 8), 2'($urandom),
           rdy, we, 8'($urandom));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule